// File: doc/BRIEF.md
# Byte-Lane Static Memory Array

This block is a synthesizable stand-in for an asynchronous 16-bit-wide static memory chip. It keeps the chip's active-low controls (chip select, output enable, write enable and one enable per byte lane) and their meaning. The bidirectional data bus is split into three parts: a write-data input, a read-data output, and a two-bit flag that shows which byte lanes would be driving. No tristate buffer is needed.

The control pins are sampled against one clock. Each cycle the block settles into one of four modes: standby, output-disabled, read or write. The mode also decides which byte lanes take part.

Reads are combinational from the stored array. Writes commit on the rising clock edge and update only the enabled bytes of the addressed word. The array has no reset.

The full-size part uses 16 address bits. The default parameter is smaller so that elaboration stays light.

Top module: `bytelane_sram`

## Requirements
- R1: The array holds 2**ADDR_W words of 16 bits, one word per value of `addr`. A full-size device uses ADDR_W = 16, and the default is ADDR_W = 10. Every address, including 0 and the highest, stores its own word.
- R2: While `cs_n` is 1, the block is in standby: `mode` = 2'b00, `lane_drv` = 2'b00, `rdata` = 0, and no write happens, whatever the other controls are.
- R3: While `cs_n` is 0 and both `lb_n` and `ub_n` are 1, the block is also in standby: `mode` = 2'b00, `lane_drv` = 2'b00, and no write happens.
- R4: Output-disabled mode applies when `cs_n` is 0, `we_n` is 1, `oe_n` is 1 and at least one byte enable is 0. In this mode `mode` = 2'b01 and `lane_drv` = 2'b00.
- R5: Read mode applies when `cs_n` is 0, `we_n` is 1, `oe_n` is 0 and at least one byte enable is 0. In this mode `mode` = 2'b10. Bit 0 of `lane_drv` is the inverse of `lb_n` and covers data bits 7:0. Bit 1 of `lane_drv` is the inverse of `ub_n` and covers data bits 15:8. A driven lane shows, in the same cycle, the stored bits of the word at `addr`.
- R6: Write mode applies when `cs_n` is 0, `we_n` is 0 and at least one byte enable is 0. In this mode `mode` = 2'b11. At the rising clock edge, each enabled byte of the word at `addr` takes the matching byte of `wdata`.
- R7: During a write, a byte whose enable is 1 keeps its previous contents.
- R8: During a write, `lane_drv` = 2'b00, whether `oe_n` is 0 or 1.
- R9: A byte lane of `rdata` whose `lane_drv` bit is 0 reads as all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; writes commit on its rising edge |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| lb_n | input | 1 | Enable for data bits 7:0, active low |
| ub_n | input | 1 | Enable for data bits 15:8, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Data to be written |
| rdata | output | 16 | Read data, zero on lanes that are not driven |
| lane_drv | output | 2 | Per-lane driver flag: bit 0 for the low byte, bit 1 for the high byte |
| mode | output | 2 | Decoded mode: 00 standby, 01 output-disabled, 10 read, 11 write |

## Verification
The assertions check on every cycle that the mode decode matches the control pins and that every standby, output-disabled and write cycle keeps both drivers off. They also check that a read maps each byte enable to its own lane, that undriven lanes read zero, and that a low byte written in one cycle reads back from the same address in the next. Only the bench's scenarios can show the following:
- a byte outside the enable mask survives a write;
- a write attempted while deselected or with both lanes disabled leaves the array untouched;
- the lowest and highest addresses hold independent words.

The bench shows these by comparing reads against a reference array it keeps itself.

// File: rtl/bytelane_sram.sv
module bytelane_sram #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              lb_n,
  input  logic              ub_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  output logic [1:0]        lane_drv,
  output logic [1:0]        mode
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LANES = 2;

  logic [15:0] mem [DEPTH];
  logic [LANES-1:0] lane_en;
  logic selected, wr_cyc, rd_cyc;
  logic [15:0] word;

  assign lane_en  = ~{ub_n, lb_n};
  assign selected = ~cs_n & (|lane_en);
  assign wr_cyc   = selected & ~we_n;
  assign rd_cyc   = selected & we_n & ~oe_n;
  assign lane_drv = rd_cyc ? lane_en : '0;
  assign word     = mem[addr];

  always_comb begin
    if (!selected)   mode = 2'b00;
    else if (wr_cyc) mode = 2'b11;
    else if (rd_cyc) mode = 2'b10;
    else             mode = 2'b01;
  end

  // R6 R7: only enabled bytes commit
  always_ff @(posedge clk) begin
    if (wr_cyc) begin
      for (int b = 0; b < LANES; b++) begin
        if (lane_en[b]) mem[addr][b*8 +: 8] <= wdata[b*8 +: 8];
      end
    end
  end

  // R9: undriven lanes read zero
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rdata[g*8 +: 8] = lane_drv[g] ? word[g*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/bytelane_sram_chk.sv
module bytelane_sram_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              cs_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              lb_n,
  input logic              ub_n,
  input logic [ADDR_W-1:0] addr,
  input logic [15:0]       wdata,
  input logic [15:0]       rdata,
  input logic [1:0]        lane_drv,
  input logic [1:0]        mode
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  a_r2_deselect_quiet: assert property (@(posedge clk) disable iff (!armed)
    cs_n |-> (mode == 2'b00 && lane_drv == 2'b00 && rdata == 16'h0));

  a_r3_no_lane_standby: assert property (@(posedge clk) disable iff (!armed)
    (!cs_n && lb_n && ub_n) |-> (mode == 2'b00 && lane_drv == 2'b00));

  a_r4_output_off: assert property (@(posedge clk) disable iff (!armed)
    (!cs_n && we_n && oe_n && !(lb_n && ub_n)) |-> (mode == 2'b01 && lane_drv == 2'b00));

  a_r5_lane_map: assert property (@(posedge clk) disable iff (!armed)
    (mode == 2'b10) |-> (lane_drv == {!ub_n, !lb_n} && we_n && !oe_n && !cs_n));

  a_r6_low_byte_readback: assert property (@(posedge clk) disable iff (!armed)
    ($past(mode == 2'b11 && !lb_n) && addr == $past(addr) && mode == 2'b10 && !lb_n)
      |-> rdata[7:0] == $past(wdata[7:0]));

  a_r8_write_no_drive: assert property (@(posedge clk) disable iff (!armed)
    (!cs_n && !we_n) |-> lane_drv == 2'b00);

  a_r9_idle_lane_zero: assert property (@(posedge clk) disable iff (!armed)
    ((!lane_drv[0] -> rdata[7:0] == 8'h00) && (!lane_drv[1] -> rdata[15:8] == 8'h00)));
endmodule

bind bytelane_sram bytelane_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .lb_n(lb_n), .ub_n(ub_n),
  .addr(addr), .wdata(wdata), .rdata(rdata), .lane_drv(lane_drv), .mode(mode)
);

// File: tb/bytelane_sram_test.sv
module bytelane_sram_test;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0] lane_drv, mode;
  logic rst = 1'b1;

  logic [15:0] ref_mem [DEPTH];
  logic [DEPTH-1:0] known = '0;
  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bytelane_sram #(.ADDR_W(AW)) uut (
    .clk(clk), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .lb_n(lb_n), .ub_n(ub_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .lane_drv(lane_drv), .mode(mode)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  task automatic drive(input logic c, input logic o, input logic w, input logic l,
                       input logic u, input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    cs_n = c; oe_n = o; we_n = w; lb_n = l; ub_n = u; addr = a; wdata = d;
    #1;
  endtask

  // write with a reference update; drivers must stay off (R8)
  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d, input logic l,
                    input logic u, input logic o);
    drive(1'b0, o, 1'b0, l, u, a, d);
    check({14'h0, mode}, 16'h3, "R6 write mode");
    check({14'h0, lane_drv}, 16'h0, "R8 no drive in write");
    @(posedge clk);
    if (!l) ref_mem[a][7:0] = d[7:0];
    if (!u) ref_mem[a][15:8] = d[15:8];
    known[a] = 1'b1;
    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, a, 16'h0);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic l, input logic u, input string tag);
    logic [15:0] exp;
    drive(1'b0, 1'b0, 1'b1, l, u, a, 16'hdead);
    exp = ref_mem[a] & {{8{!u}}, {8{!l}}};
    check({14'h0, lane_drv}, {14'h0, !u, !l}, "R5 lane flags");
    check({14'h0, mode}, (l && u) ? 16'h0 : 16'h2, "R5 read mode");
    check(rdata, exp, tag);
  endtask

  task automatic t_idle();
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, '0, 16'h0);
    check({14'h0, mode}, 16'h0, "R2 deselected mode");
    check({14'h0, lane_drv}, 16'h0, "R2 deselected drivers");
    check(rdata, 16'h0, "R2 deselected data");
  endtask

  task automatic t_full_words();
    for (int i = 0; i < 16; i++) wr(AW'(i * 37 + 3), 16'(i * 16'h1357 + 16'h0a5c), 1'b0, 1'b0, i[0]);
    for (int i = 0; i < 16; i++) rd(AW'(i * 37 + 3), 1'b0, 1'b0, "R6 full word readback");
  endtask

  task automatic t_byte_masks();
    wr(AW'(100), 16'h1234, 1'b0, 1'b0, 1'b1);
    wr(AW'(100), 16'hffab, 1'b0, 1'b1, 1'b1);
    rd(AW'(100), 1'b0, 1'b0, "R7 upper kept on low write");
    wr(AW'(100), 16'hcdff, 1'b1, 1'b0, 1'b0);
    rd(AW'(100), 1'b0, 1'b0, "R7 lower kept on high write");
    rd(AW'(100), 1'b0, 1'b1, "R9 only low lane");
    rd(AW'(100), 1'b1, 1'b0, "R9 only high lane");
  endtask

  task automatic t_blocked_writes();
    wr(AW'(200), 16'h5a5a, 1'b0, 1'b0, 1'b1);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, AW'(200), 16'h0000);
    check({14'h0, lane_drv}, 16'h0, "R2 deselected write drivers");
    @(posedge clk);
    rd(AW'(200), 1'b0, 1'b0, "R2 no write when deselected");
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, AW'(200), 16'h0000);
    check({14'h0, mode}, 16'h0, "R3 standby mode");
    check({14'h0, lane_drv}, 16'h0, "R3 standby drivers");
    @(posedge clk);
    rd(AW'(200), 1'b0, 1'b0, "R3 no write without lanes");
  endtask

  task automatic t_output_off();
    drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, AW'(200), 16'h0);
    check({14'h0, mode}, 16'h1, "R4 output-disabled mode");
    check({14'h0, lane_drv}, 16'h0, "R4 drivers off");
    check(rdata, 16'h0, "R9 data zero when off");
  endtask

  task automatic t_bounds();
    wr('0, 16'h0001, 1'b0, 1'b0, 1'b0);
    wr('1, 16'hfffe, 1'b0, 1'b0, 1'b1);
    rd('0, 1'b0, 1'b0, "R1 lowest address");
    rd('1, 1'b0, 1'b0, "R1 highest address");
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 16'h0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    t_idle();
    t_bounds();
    t_full_words();
    t_byte_masks();
    t_blocked_writes();
    t_output_off();
    done = 1'b1;
    report();
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end
endmodule